// File: doc/BRIEF.md
# Time Slot Interchange Core

This block moves byte-wide time slots between channel positions of a repeating frame of 32 slots. One byte arrives per clock on a parallel receive port. A frame pulse marks the cycle that carries slot 0. For each outgoing slot, a connection entry names the source slot and picks one of two latency modes. Variable delay reads a live copy of the last received bytes and gives the lowest latency. Constant delay reads one of three frame buffers used in rotation, so the bytes of one input frame leave together and keep their frame order. The transmit byte for slot d leaves in the same clock cycle as the receive byte for slot d.

Each entry can also turn the output on and off, and can loop the outgoing byte of that channel back into the receive path at the same slot position. This supports a diagnostic path with no external wiring. A simple write port loads the entries, one per cycle, while traffic runs. Each write takes effect from the next clock edge.

Top module: `tsi_core`

## Requirements
- R1: After reset, all buffers and connection entries are zero, `tx_en` is 0 and `tx_data` is 8'hFF. This holds through the first two cycles after reset is released.
- R2: Entry layout: bits 4:0 give the source slot n, bit 9 loopback, bit 10 mode (0 variable, 1 constant) and bit 11 output enable. In variable mode, when (d-n) mod 32 is 3 or more, the byte received at slot n comes out at slot d of the same frame, (d-n) mod 32 cycles later.
- R3: In variable mode, when (d-n) mod 32 is 0, 1 or 2, the byte comes out one frame later, (d-n) mod 32 + 32 cycles after it was received.
- R4: In constant mode, a byte received at slot n of frame k comes out at slot d of frame k+2, exactly 64+d-n cycles later. This holds for every pair of n and d.
- R5: Constant mode keeps three frame buffers in rotation, and the buffer changes on every frame pulse. Output slots 0 and 1 are read before their frame begins, and they still return data from frame k-2.
- R6: When bit 9 of the entry for slot s is 1, the byte sent at slot s is stored in place of `rx_data` as the received byte of slot s. Later reads of slot s, in either mode, return that byte.
- R7: `tx_en` equals bit 11 of the entry used for the outgoing slot. When it is 0, `tx_data` is 8'hFF.
- R8: The frame pulse restarts the slot count at 0. Without a pulse, the count rises by one each cycle and wraps after slot 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp | input | 1 | Frame pulse, high in the cycle of slot 0 |
| rx_data | input | 8 | Received byte of the current slot |
| cfg_we | input | 1 | Connection entry write strobe |
| cfg_slot | input | 5 | Output slot whose entry is written |
| cfg_entry | input | 12 | Entry value: source, loopback, mode, enable |
| tx_data | output | 8 | Outgoing byte of the current slot |
| tx_en | output | 1 | Output enable of the current slot |

## Verification
The assertions assume that frame pulses come every 32 cycles, starting in the first cycle after reset, so that slot numbers and buffer rotation line up with the frame. The stimulus drives the pulse from the cycle count for this reason. It draws receive bytes and connection entries at random from a fixed seed and rewrites entries while traffic runs. It adds directed entries for the wrap cases at slots 0, 1, 31 and at a distance of two or three slots. The expected output is rebuilt from a record of every byte received, so it accounts for loopback and for entries that change mid-frame.

// File: rtl/tsi_core.sv
module tsi_core #(
  parameter int SLOTS = 32,
  parameter int W     = 8,
  localparam int SW   = $clog2(SLOTS),
  localparam int LB   = 9,
  localparam int CD   = 10,
  localparam int OE   = 11,
  localparam int EW   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp,
  input  logic [W-1:0]  rx_data,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_slot,
  input  logic [EW-1:0] cfg_entry,
  output logic [W-1:0]  tx_data,
  output logic          tx_en
);

  function automatic logic [1:0] inc3(input logic [1:0] v);
    return (v == 2'd2) ? 2'd0 : v + 2'd1;
  endfunction

  logic [SW-1:0] slot_q, cur, rd;
  logic [1:0]    fw_q, fw, rbank;
  logic [EW-1:0] cm [SLOTS];
  logic [W-1:0]  live [SLOTS];
  logic [W-1:0]  bank [3][SLOTS];
  logic [EW-1:0] re, ce;
  logic [W-1:0]  p1, p2, rbyte, wdata;
  logic          oe1, oe2, late;

  assign cur   = fp ? '0 : ((slot_q == SW'(SLOTS-1)) ? '0 : slot_q + 1'b1);
  assign fw    = fp ? inc3(fw_q) : fw_q;
  assign late  = cur >= SW'(SLOTS-2);
  assign rd    = late ? cur - SW'(SLOTS-2) : cur + SW'(2);
  assign rbank = late ? inc3(inc3(fw)) : inc3(fw);
  assign re    = cm[rd];
  assign ce    = cm[cur];
  assign rbyte = re[CD] ? bank[rbank][re[SW-1:0]] : live[re[SW-1:0]];
  assign wdata = ce[LB] ? p2 : rx_data;
  assign tx_data = oe2 ? p2 : '1;
  assign tx_en   = oe2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SW'(SLOTS-1);
      fw_q   <= 2'd2;
      p1 <= '0; p2 <= '0; oe1 <= 1'b0; oe2 <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
        cm[i]   <= '0;
        live[i] <= '0;
        for (int b = 0; b < 3; b++) bank[b][i] <= '0;
      end
    end else begin
      slot_q <= cur;
      fw_q   <= fw;
      live[cur]     <= wdata;
      bank[fw][cur] <= wdata;
      p1  <= rbyte;
      oe1 <= re[OE];
      p2  <= p1;
      oe2 <= oe1;
      if (cfg_we) cm[cfg_slot] <= cfg_entry;
    end
  end

endmodule

// File: rtl/tsi_core_checker.sv
module tsi_core_checker #(
  parameter int SLOTS = 32,
  parameter int SW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fp,
  input logic [SW-1:0] slot_q,
  input logic [1:0]    fw_q,
  input logic          oe1,
  input logic          tx_en
);

  AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> slot_q == '0); // R8

  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp && slot_q != SW'(SLOTS-1)) |=> slot_q == $past(slot_q) + SW'(1)); // R8

  AST_BANK_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> fw_q != $past(fw_q)); // R5

  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fw_q != 2'd3); // R5

  AST_OE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en == $past(oe1)); // R7

endmodule

bind tsi_core tsi_core_checker #(.SLOTS(SLOTS), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fp(fp), .slot_q(slot_q),
  .fw_q(fw_q), .oe1(oe1), .tx_en(tx_en)
);

// File: tb/test_tsi_core.sv
module test_tsi_core;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fp = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_slot = '0;
  logic [11:0] cfg_entry = '0;
  logic [7:0]  tx_data;
  logic        tx_en;

  tsi_core i_tsi_core (
    .clk(clk), .rst_n(rst_n), .fp(fp), .rx_data(rx_data),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_entry(cfg_entry),
    .tx_data(tx_data), .tx_en(tx_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int t = 0;
  bit done = 1'b0;
  logic [11:0] mcm [32];
  logic [11:0] rdent [NCYC];
  logic [7:0]  hist [NCYC];
  bit          hist_lb [NCYC];
  int unsigned seed_dummy;

  function automatic logic [11:0] mk(input bit oe, input bit cd, input bit lb, input int src);
    return {oe, cd, lb, 4'b0000, 5'(src)};
  endfunction

  task automatic step(input bit we, input logic [4:0] s, input logic [11:0] e, input string ph);
    int slot, dly, S, n;
    logic [11:0] ee;
    logic [7:0] raw, exp_data;
    bit en;
    string tag;
    fp = (t % 32 == 0);
    rx_data = 8'($urandom);
    cfg_we = we; cfg_slot = s; cfg_entry = e;
    #1;
    slot = t % 32;
    rdent[t] = mcm[(slot + 2) % 32];
    S = -1;
    if (t < 2) begin
      raw = '0; en = 1'b0; tag = "R1";
    end else begin
      ee = rdent[t-2];
      n = int'(ee[4:0]);
      if (ee[10]) dly = 64 + slot - n;
      else begin
        dly = (slot - n + 32) % 32;
        if (dly < 3) dly += 32;
      end
      S = t - dly;
      raw = (S < 0) ? 8'h00 : hist[S];
      en = ee[11];
      if (!en) tag = "R7";
      else if (S >= 0 && hist_lb[S]) tag = "R6";
      else if (ee[10]) tag = (slot < 2) ? "R5" : "R4";
      else if (dly >= 32) tag = "R3";
      else tag = "R2";
      if (ph == "ident" && en) tag = {tag, "/R8"};
    end
    exp_data = en ? raw : 8'hFF;
    checks++;
    if (tx_en !== en || tx_data !== exp_data) begin
      errors++;
      $display("FAIL %s t=%0d slot=%0d: tx_en=%b tx_data=%h expected tx_en=%b tx_data=%h",
               tag, t, slot, tx_en, tx_data, en, exp_data);
    end
    hist[t] = mcm[slot][9] ? raw : rx_data;
    hist_lb[t] = mcm[slot][9];
    if (we) mcm[s] = e;
    t++;
    @(negedge clk);
  endtask

  task automatic run(input int frames, input string ph);
    logic [11:0] e;
    int d, src;
    for (int f = 0; f < frames; f++) begin
      for (int k = 0; k < 32; k++) begin
        d = (t + 2) % 32;
        src = int'($urandom % 32);
        case (ph)
          "ident":  e = mk(1, 0, 0, d);
          "var":    e = mk(1, 0, 0, src);
          "const":  e = mk(1, 1, 0, src);
          "mixed":  e = mk($urandom % 8 != 0, $urandom % 2, $urandom % 4 == 0, src);
          "off":    e = mk(0, $urandom % 2, 0, src);
          default: begin
            case (d)
              0:  e = mk(1, 1, 0, 31);
              31: e = mk(1, 1, 0, 0);
              1:  e = mk(1, 0, 0, 30);
              5:  e = mk(1, 0, 0, 3);
              9:  e = mk(1, 0, 0, 6);
              10: e = mk(1, 0, 0, 10);
              12: e = mk(1, 0, 1, 11);
              13: e = mk(1, 1, 0, 12);
              default: e = mk(1, 0, 0, src);
            endcase
          end
        endcase
        step(f == 0, 5'(d), e, ph);
      end
    end
  endtask

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    for (int i = 0; i < 32; i++) mcm[i] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (tx_en !== 1'b0 || tx_data !== 8'hFF) begin
      errors++;
      $display("FAIL R1 in reset: tx_en=%b tx_data=%h expected tx_en=0 tx_data=ff", tx_en, tx_data);
    end
    rst_n = 1'b1;
    run(4, "ident");
    run(6, "var");
    run(6, "const");
    run(10, "mixed");
    run(4, "direct");
    run(3, "off");
    run(3, "mixed");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule